// File: doc/BRIEF.md
# Multi-Width Integer Add Unit

This block performs the integer additions of a 64-bit register machine on a single registered stage. Each request carries a 4-bit form select, two register values, an immediate, a memory operand value and the prior contents of the destination register. The form select chooses the width of the addition and how each operand is sign-extended. It also chooses which part of the destination the sum replaces. The forms are a full 64-bit add, a 64-bit add of a sign-extended word or halfword, a 32-bit add into the low word, and a 32-bit add into the high word.

The bits are numbered left to right, so bit 0 is the most significant bit. The "upper word" (bits 0..31 in that numbering) is `[63:32]` in this code and the "lower word" (bits 32..63) is `[31:0]`. The unit does not know which register is the destination. The issuer passes the destination's old value on `in_keep`. For a two-address form that value equals `in_a`. For a three-address form it is the separate target register, so the sources stay unmodified. Any bits the form does not write are copied from `in_keep`.

Both sides of the unit use valid/ready handshakes. A request is taken when `in_valid` and `in_ready` are both high. The result appears one cycle later with `out_valid` high. It stays there, unchanged, until `out_ready` is high. `in_ready` is high when the output register is empty or is being drained in the same cycle. A stall at the output therefore stops new requests without losing any.

Top module: `wide_add_unit`

## Requirements
- R1: Form codes 0 and 1 add `in_a` to `in_b` (code 0) or to `in_mem` (code 1) at 64 bits and write all 64 result bits.
- R2: Form code 2 adds `in_a` to `in_b[31:0]` sign-extended to 64 bits. Form code 3 adds `in_a` to `in_imm[31:0]` sign-extended to 64 bits. Both write all 64 bits.
- R3: Form code 4 adds `in_a` to `in_imm[15:0]` sign-extended to 64 bits and writes all 64 bits. The result comes only from `in_a` and the immediate, so it serves as a three-address form.
- R4: Form codes 5, 6 and 7 add `in_a[31:0]` to `in_b[31:0]`, `in_mem[31:0]` or `in_imm` respectively at 32 bits. The sum goes to `out_result[31:0]` and `out_result[63:32]` equals `in_keep[63:32]`.
- R5: Form code 8 adds `in_a[31:0]` to `in_mem[15:0]` sign-extended to 32 bits. Form code 9 adds `in_a[31:0]` to `in_imm[15:0]` sign-extended to 32 bits. The upper word comes from `in_keep[63:32]`.
- R6: Form code 10 adds `in_a[63:32]` to `in_b[63:32]` and form code 11 adds `in_a[63:32]` to `in_imm`. The 32-bit sum goes to `out_result[63:32]` and `out_result[31:0]` equals `in_keep[31:0]`.
- R7: `out_cc` is computed at the width of the form: 0 for a zero sum, 1 for a negative sum, 2 for a positive sum and 3 on signed overflow. Overflow takes precedence over the other codes.
- R8: `out_ovf` is 1 when both operands of the addition have the same sign and the sum's sign differs from it. The written sum is the sum modulo 2 to the power of the width.
- R9: After reset `out_valid` is 0 and `in_ready` is 1. A request taken on one clock edge appears on the outputs after the next edge, with one cycle of latency.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the outputs hold their values. If the output is drained and a new request is taken on the same edge, the new result replaces the old one with no gap.
- R11: Form codes 12 to 15 are not assigned and behave exactly like form code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 4 | Form select code |
| in_a | input | 64 | First register source |
| in_b | input | 64 | Second register source |
| in_imm | input | 32 | Immediate operand |
| in_mem | input | 64 | Memory operand value |
| in_keep | input | 64 | Prior destination contents, source of unwritten bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | New destination value |
| out_cc | output | 2 | Condition code |
| out_ovf | output | 1 | Signed overflow flag |

## Verification
The two functions that can fall in the same cycle are draining a finished result and taking the next request. The bench stalls the output with a result held and a second request waiting on the input. It checks that `in_ready` stays low and the held result does not move. It then raises `out_ready`, which makes the drain and the accept happen on one edge, and checks that the second sum follows on the very next cycle. A separate sweep over all sixteen form codes uses boundary operands, including sign-bit, all-ones and halfword-edge values. For each request the bench computes the expected result, condition code and overflow flag arithmetically.

// File: rtl/wau_pkg.sv
package wau_pkg;

  typedef enum logic [3:0] {
    FORM_FULL_RR  = 4'd0,
    FORM_FULL_RM  = 4'd1,
    FORM_FULL_RW  = 4'd2,
    FORM_FULL_IW  = 4'd3,
    FORM_FULL_IS  = 4'd4,
    FORM_LOW_RR   = 4'd5,
    FORM_LOW_RM   = 4'd6,
    FORM_LOW_IW   = 4'd7,
    FORM_LOW_MS   = 4'd8,
    FORM_LOW_IS   = 4'd9,
    FORM_HIGH_RR  = 4'd10,
    FORM_HIGH_IW  = 4'd11
  } form_e;

  typedef enum logic [1:0] {
    LANE_FULL = 2'd0,
    LANE_LOW  = 2'd1,
    LANE_HIGH = 2'd2
  } lane_e;

  typedef enum logic [1:0] {
    CC_ZERO = 2'd0,
    CC_NEG  = 2'd1,
    CC_POS  = 2'd2,
    CC_OVF  = 2'd3
  } cc_e;

  function automatic lane_e lane_of(input logic [3:0] code);
    case (code)
      FORM_LOW_RR, FORM_LOW_RM, FORM_LOW_IW, FORM_LOW_MS, FORM_LOW_IS: lane_of = LANE_LOW;
      FORM_HIGH_RR, FORM_HIGH_IW:                                      lane_of = LANE_HIGH;
      default:                                                         lane_of = LANE_FULL;
    endcase
  endfunction

endpackage

// File: rtl/wau_operand_sel.sv
module wau_operand_sel
  import wau_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHORT_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [3:0]        form,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [HALF_W-1:0] imm,
  input  logic [DATA_W-1:0] mem,
  output lane_e             lane,
  output logic [DATA_W-1:0] full_x,
  output logic [DATA_W-1:0] full_y,
  output logic [HALF_W-1:0] part_x,
  output logic [HALF_W-1:0] part_y
);

  localparam int EXT_WF = DATA_W - HALF_W;
  localparam int EXT_SF = DATA_W - SHORT_W;
  localparam int EXT_SH = HALF_W - SHORT_W;

  logic [DATA_W-1:0] b_word_sx, imm_word_sx, imm_short_sx;
  logic [HALF_W-1:0] mem_short_sx32, imm_short_sx32;

  assign b_word_sx      = {{EXT_WF{src_b[HALF_W-1]}}, src_b[HALF_W-1:0]};
  assign imm_word_sx    = {{EXT_WF{imm[HALF_W-1]}}, imm};
  assign imm_short_sx   = {{EXT_SF{imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};
  assign mem_short_sx32 = {{EXT_SH{mem[SHORT_W-1]}}, mem[SHORT_W-1:0]};
  assign imm_short_sx32 = {{EXT_SH{imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};

  assign lane = lane_of(form);

  always_comb begin
    full_x = src_a;
    full_y = src_b;
    part_x = src_a[HALF_W-1:0];
    part_y = src_b[HALF_W-1:0];
    case (form)
      FORM_FULL_RM:  full_y = mem;
      FORM_FULL_RW:  full_y = b_word_sx;
      FORM_FULL_IW:  full_y = imm_word_sx;
      FORM_FULL_IS:  full_y = imm_short_sx;
      FORM_LOW_RM:   part_y = mem[HALF_W-1:0];
      FORM_LOW_IW:   part_y = imm;
      FORM_LOW_MS:   part_y = mem_short_sx32;
      FORM_LOW_IS:   part_y = imm_short_sx32;
      FORM_HIGH_RR: begin
        part_x = src_a[DATA_W-1:HALF_W];
        part_y = src_b[DATA_W-1:HALF_W];
      end
      FORM_HIGH_IW: begin
        part_x = src_a[DATA_W-1:HALF_W];
        part_y = imm;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wau_adder.sv
module wau_adder
  import wau_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic [1:0]   cc
);

  assign sum = x + y;
  assign ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

  always_comb begin
    if (ovf)             cc = CC_OVF;
    else if (sum == '0)  cc = CC_ZERO;
    else if (sum[W-1])   cc = CC_NEG;
    else                 cc = CC_POS;
  end

endmodule

// File: rtl/wide_add_unit.sv
module wide_add_unit
  import wau_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHORT_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [HALF_W-1:0] in_imm,
  input  logic [DATA_W-1:0] in_mem,
  input  logic [DATA_W-1:0] in_keep,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [1:0]        out_cc,
  output logic              out_ovf
);

  lane_e             lane;
  logic [DATA_W-1:0] full_x, full_y, full_sum;
  logic [HALF_W-1:0] part_x, part_y, part_sum;
  logic              full_ovf, part_ovf;
  logic [1:0]        full_cc, part_cc;
  logic              fire;

  wau_operand_sel #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_sel (
    .form(in_op), .src_a(in_a), .src_b(in_b), .imm(in_imm), .mem(in_mem),
    .lane(lane), .full_x(full_x), .full_y(full_y), .part_x(part_x), .part_y(part_y)
  );

  wau_adder #(.W(DATA_W)) u_full_add (
    .x(full_x), .y(full_y), .sum(full_sum), .ovf(full_ovf), .cc(full_cc)
  );

  wau_adder #(.W(HALF_W)) u_part_add (
    .x(part_x), .y(part_y), .sum(part_sum), .ovf(part_ovf), .cc(part_cc)
  );

  logic [DATA_W-1:0] next_result;
  logic [1:0]        next_cc;
  logic              next_ovf;

  always_comb begin
    case (lane)
      LANE_LOW: begin
        next_result = {in_keep[DATA_W-1:HALF_W], part_sum};
        next_cc     = part_cc;
        next_ovf    = part_ovf;
      end
      LANE_HIGH: begin
        next_result = {part_sum, in_keep[HALF_W-1:0]};
        next_cc     = part_cc;
        next_ovf    = part_ovf;
      end
      default: begin
        next_result = full_sum;
        next_cc     = full_cc;
        next_ovf    = full_ovf;
      end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cc     <= CC_ZERO;
      out_ovf    <= 1'b0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_result <= next_result;
      out_cc     <= next_cc;
      out_ovf    <= next_ovf;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_cc) && $stable(out_ovf)));

  a_r4_low_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && lane == LANE_LOW) |=>
      out_result[DATA_W-1:HALF_W] == $past(in_keep[DATA_W-1:HALF_W]));

  a_r6_high_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && lane == LANE_HIGH) |=>
      out_result[HALF_W-1:0] == $past(in_keep[HALF_W-1:0]));

  a_r7_ovf_cc: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> out_cc == CC_OVF);

  a_r1_full_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == FORM_FULL_RR)) |=>
      out_result == $past(in_a) + $past(in_b));

endmodule

// File: tb/wide_add_unit_test.sv
`timescale 1ns/1ps
module wide_add_unit_test;

  localparam int MAX_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0, in_mem = '0, in_keep = '0;
  logic [31:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [1:0]  out_cc;
  logic        out_ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wide_add_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm), .in_mem(in_mem),
    .in_keep(in_keep), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_cc(out_cc), .out_ovf(out_ovf)
  );

  function automatic string req_of(int code);
    case (code)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4:       return "R3";
      5, 6, 7: return "R4";
      8, 9:    return "R5";
      10, 11:  return "R6";
      default: return "R11";
    endcase
  endfunction

  // returns {result, cc, ovf}
  function automatic logic [66:0] model(int code, logic [63:0] a, logic [63:0] b,
                                        logic [31:0] im, logic [63:0] m, logic [63:0] k);
    logic [63:0] x, y, s;
    logic signed [65:0] t, hi_lim, lo_lim;
    int lane;  // 0 full, 1 low word, 2 high word
    logic ov;
    logic [1:0] cc;
    logic [63:0] res;
    lane = 0;
    x = a;
    y = b;
    case (code)
      1:  y = m;
      2:  y = 64'($signed(b[31:0]));
      3:  y = 64'($signed(im));
      4:  y = 64'($signed(im[15:0]));
      5:  begin lane = 1; x = 64'($signed(a[31:0])); y = 64'($signed(b[31:0])); end
      6:  begin lane = 1; x = 64'($signed(a[31:0])); y = 64'($signed(m[31:0])); end
      7:  begin lane = 1; x = 64'($signed(a[31:0])); y = 64'($signed(im)); end
      8:  begin lane = 1; x = 64'($signed(a[31:0])); y = 64'($signed(m[15:0])); end
      9:  begin lane = 1; x = 64'($signed(a[31:0])); y = 64'($signed(im[15:0])); end
      10: begin lane = 2; x = 64'($signed(a[63:32])); y = 64'($signed(b[63:32])); end
      11: begin lane = 2; x = 64'($signed(a[63:32])); y = 64'($signed(im)); end
      default: ;
    endcase
    t = $signed({{2{x[63]}}, x}) + $signed({{2{y[63]}}, y});
    if (lane == 0) begin
      hi_lim = (66'sd1 <<< 63) - 66'sd1;
      lo_lim = -(66'sd1 <<< 63);
      s = t[63:0];
    end else begin
      hi_lim = (66'sd1 <<< 31) - 66'sd1;
      lo_lim = -(66'sd1 <<< 31);
      s = 64'($signed(t[31:0]));
    end
    ov = (t > hi_lim) || (t < lo_lim);
    if (ov) cc = 2'd3;
    else if (s == 64'd0) cc = 2'd0;
    else if (s[63]) cc = 2'd1;
    else cc = 2'd2;
    case (lane)
      1:       res = {k[63:32], t[31:0]};
      2:       res = {t[31:0], k[31:0]};
      default: res = t[63:0];
    endcase
    return {res, cc, ov};
  endfunction

  task automatic check(input bit ok, input string what,
                       input logic [66:0] got, input logic [66:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic one_request(int code, logic [63:0] a, logic [63:0] b,
                             logic [31:0] im, logic [63:0] m, logic [63:0] k);
    logic [66:0] exp, got;
    @(negedge clk);
    in_op = 4'(code); in_a = a; in_b = b; in_imm = im; in_mem = m; in_keep = k;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(code, a, b, im, m, k);
    got = {out_result, out_cc, out_ovf};
    check(out_valid && got == exp,
          $sformatf("%s,R7,R8 form %0d a=%h b=%h", req_of(code), code, a, b), got, exp);
  endtask

  logic [63:0] vals [8];

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    vals[0] = 64'h0;
    vals[1] = 64'h1;
    vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    vals[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[4] = 64'h8000_0000_0000_0000;
    vals[5] = 64'h0000_0000_7FFF_FFFF;
    vals[6] = 64'hFFFF_FFFF_8000_8000;
    vals[7] = 64'h7FFF_FFFF_0000_7FFF;

    repeat (3) @(negedge clk);
    // R9: reset state
    check(!out_valid && in_ready, "R9 reset state",
          {65'd0, out_valid, in_ready}, {65'd0, 2'b01});
    rst_n = 1'b1;

    // R1..R8, R11: sweep of every form code over boundary operands
    for (int code = 0; code < 16; code++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          one_request(code, vals[i], vals[j], vals[j][31:0] ^ 32'(i),
                      vals[(j + 5) % 8], vals[(i + 3) % 8] ^ 64'h5A5A_C3C3_0F0F_9696);

    // R10: stall, then drain and accept on the same edge
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'd0; in_a = 64'd1; in_b = 64'd2; in_valid = 1'b1;
    @(negedge clk);
    in_a = 64'd10; in_b = 64'd20;
    check(out_valid && out_result == 64'd3 && !in_ready, "R10 first result held",
          {out_result, 1'b0, out_valid, in_ready}, {64'd3, 3'b010});
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check(out_valid && out_result == 64'd3 && !in_ready, "R10 stall keeps output",
            {out_result, 1'b0, out_valid, in_ready}, {64'd3, 3'b010});
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == 64'd30, "R10 drain and accept same edge",
          {out_result, 2'b0, out_valid}, {64'd30, 3'b001});
    @(negedge clk);
    check(!out_valid, "R9 output empties after drain",
          {66'd0, out_valid}, 67'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule